// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 8-bit ports, A and B. Each direction has a private storage register with its own capture clock. A rising edge on the A capture clock stores the A-port input. A rising edge on the B capture clock stores the B-port input. Capture ignores the select and enable inputs, and the two registers may capture at the same moment.

Each direction has a source select. It chooses whether that direction sends the live value from the opposite port or the contents of the register. The chosen value reaches the output port through an AND-OR multiplexer that is registered on the system clock. A select change therefore takes effect only on a system clock edge and never shows up as a transient on the pins.

Each port is modelled as three vectors: an input, an output and an output-enable. The A-to-B driver enable is active high. The B-to-A driver enable is active low. When both drivers are on, both directions are forced to stored data, so live data cannot loop between the ports.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0 and both data outputs are 0. Reset clears both storage registers to zero, and they read back as zero after release.
- R2: A rising edge on `a_clk` stores `a_in` into the A register, whatever the selects and enables are.
- R3: A rising edge on `b_clk` stores `b_in` into the B register, whatever the selects and enables are.
- R4: If `a_clk` and `b_clk` rise in the same system cycle, both registers capture, each keeping its own port's data.
- R5: With `b_src_reg` = 0 (live) and the force condition of R9 absent, `b_out` equals `a_in` as sampled at the previous `clk` rising edge.
- R6: With `b_src_reg` = 1 (stored), `b_out` equals the A register as sampled at the previous `clk` rising edge.
- R7: For the B-to-A direction, `a_src_reg` = 0 gives `a_out` the previous-edge `b_in`, and `a_src_reg` = 1 gives the B register. The force condition of R9 overrides the live choice.
- R8: `b_oe` equals `a2b_en` and `a_oe` equals the inverse of `b2a_en_n`, both as sampled at the previous `clk` edge.
- R9: When `a2b_en` = 1 and `b2a_en_n` = 0, both outputs carry stored register data whatever the selects are.
- R10: A storage register keeps its value for as long as its capture clock stays idle, even while the selects, enables and port inputs change.
- R11: A change on a select or a data input between `clk` edges does not change `a_out` or `b_out` before the next `clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_clk | input | 1 | Capture clock of the A register (rising edge) |
| b_clk | input | 1 | Capture clock of the B register (rising edge) |
| a_in | input | WIDTH | Value seen on the A port |
| a_out | output | WIDTH | Value driven onto the A port |
| a_oe | output | 1 | Drive enable of the A port |
| b_in | input | WIDTH | Value seen on the B port |
| b_out | output | WIDTH | Value driven onto the B port |
| b_oe | output | 1 | Drive enable of the B port |
| a2b_en | input | 1 | A-to-B driver enable, active high |
| b2a_en_n | input | 1 | B-to-A driver enable, active low |
| b_src_reg | input | 1 | B output source: 0 live A, 1 A register |
| a_src_reg | input | 1 | A output source: 0 live B, 1 B register |

## Verification
Random traffic mixes all four enable combinations with independent selects and random capture pulses on either clock, on both clocks or on neither. This separates the live and stored paths and shows that the both-enabled override wins over a live select. Directed runs capture different values into the two registers at once, then hold them through many cycles of toggled controls and data with the capture clocks idle. A select or data change placed between system edges is sampled before the next edge to show the output stays put. A reset in the middle of traffic, after non-zero captures, shows the registers return to zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             cap_clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nx;

  always_comb begin
    q_nx = d;
  end

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/xcvr_path_drv.sv
module xcvr_path_drv
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             sel_stored,
  input  logic             force_stored,
  input  logic             drv_en,
  output logic [WIDTH-1:0] q,
  output logic             oe
);
  src_e             src_nx;
  logic [WIDTH-1:0] pick_mask;
  logic [WIDTH-1:0] q_nx;

  always_comb begin
    src_nx    = (sel_stored || force_stored) ? SRC_STORED : SRC_LIVE;
    pick_mask = {WIDTH{src_nx == SRC_STORED}};
    q_nx      = (stored & pick_mask) | (live & ~pick_mask);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      q  <= '0;
      oe <= 1'b0;
    end else begin
      q  <= q_nx;
      oe <= drv_en;
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_clk,
  input  logic             b_clk,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             a2b_en,
  input  logic             b2a_en_n,
  input  logic             b_src_reg,
  input  logic             a_src_reg
);
  logic             sys_rst_n;
  logic [WIDTH-1:0] reg_a;
  logic [WIDTH-1:0] reg_b;
  logic             both_on;

  assign both_on = a2b_en & ~b2a_en_n;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (sys_rst_n)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_cap_a (
    .cap_clk (a_clk),
    .rst_n   (rst_n),
    .d       (a_in),
    .q       (reg_a)
  );

  xcvr_cap_reg #(.WIDTH(WIDTH)) u_cap_b (
    .cap_clk (b_clk),
    .rst_n   (rst_n),
    .d       (b_in),
    .q       (reg_b)
  );

  xcvr_path_drv #(.WIDTH(WIDTH)) u_drv_b (
    .clk          (clk),
    .srst_n       (sys_rst_n),
    .live         (a_in),
    .stored       (reg_a),
    .sel_stored   (b_src_reg),
    .force_stored (both_on),
    .drv_en       (a2b_en),
    .q            (b_out),
    .oe           (b_oe)
  );

  xcvr_path_drv #(.WIDTH(WIDTH)) u_drv_a (
    .clk          (clk),
    .srst_n       (sys_rst_n),
    .live         (b_in),
    .stored       (reg_b),
    .sel_stored   (a_src_reg),
    .force_stored (both_on),
    .drv_en       (~b2a_en_n),
    .q            (a_out),
    .oe           (a_oe)
  );
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             a_oe,
  input logic             b_oe,
  input logic             a2b_en,
  input logic             b2a_en_n,
  input logic             b_src_reg,
  input logic             a_src_reg,
  input logic [WIDTH-1:0] reg_a,
  input logic [WIDTH-1:0] reg_b
);
  logic armed;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  // R8
  b_oe_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    armed |-> b_oe == $past(a2b_en));

  // R8
  a_oe_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    armed |-> a_oe == !$past(b2a_en_n));

  // R5
  b_live_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (armed && !$past(b_src_reg) && !($past(a2b_en) && !$past(b2a_en_n)))
      |-> b_out == $past(a_in));

  // R6
  b_stored_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (armed && $past(b_src_reg)) |-> b_out == $past(reg_a));

  // R7
  a_live_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (armed && !$past(a_src_reg) && !($past(a2b_en) && !$past(b2a_en_n)))
      |-> a_out == $past(b_in));

  // R9
  both_on_stored_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (armed && $past(a2b_en) && !$past(b2a_en_n))
      |-> (b_out == $past(reg_a) && a_out == $past(reg_b)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (sys_rst_n),
  .a_in      (a_in),
  .b_in      (b_in),
  .a_out     (a_out),
  .b_out     (b_out),
  .a_oe      (a_oe),
  .b_oe      (b_oe),
  .a2b_en    (a2b_en),
  .b2a_en_n  (b2a_en_n),
  .b_src_reg (b_src_reg),
  .a_src_reg (a_src_reg),
  .reg_a     (reg_a),
  .reg_b     (reg_b)
);

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/1ps
module tb_regbus_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_clk, b_clk;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  logic         a2b_en, b2a_en_n, b_src_reg, a_src_reg;

  int           n_chk = 0;
  int           n_fail = 0;
  logic [W-1:0] m_a = '0;
  logic [W-1:0] m_b = '0;
  int unsigned  seed_dummy;

  always #5 clk = ~clk;

  regbus_xcvr #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_clk(a_clk), .b_clk(b_clk),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
    .b_src_reg(b_src_reg), .a_src_reg(a_src_reg)
  );

  function automatic logic [W-1:0] exp_b(logic sab, logic ge, logic gn, logic [W-1:0] a, logic [W-1:0] ra);
    return (sab || (ge && !gn)) ? ra : a;
  endfunction

  function automatic logic [W-1:0] exp_a(logic sba, logic ge, logic gn, logic [W-1:0] b, logic [W-1:0] rb);
    return (sba || (ge && !gn)) ? rb : b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one system cycle: apply at negedge, optional capture pulses before the edge, check at next negedge
  task automatic cycle(string req, logic [W-1:0] a, logic [W-1:0] b, logic sab, logic sba,
                       logic ge, logic gn, logic pa, logic pb);
    @(negedge clk);
    a_in = a; b_in = b; b_src_reg = sab; a_src_reg = sba; a2b_en = ge; b2a_en_n = gn;
    if (pa || pb) begin
      #1; a_clk = pa; b_clk = pb;
      #1; a_clk = 1'b0; b_clk = 1'b0;
      if (pa) m_a = a;
      if (pb) m_b = b;
    end
    @(negedge clk);
    chk(req, {24'd0, b_out}, {24'd0, exp_b(sab, ge, gn, a, m_a)});
    chk(req, {24'd0, a_out}, {24'd0, exp_a(sba, ge, gn, b, m_b)});
    chk(req, {31'd0, b_oe}, {31'd0, ge});
    chk(req, {31'd0, a_oe}, {31'd0, !gn});
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_0c7a);
    rst_n = 1'b0; a_clk = 1'b0; b_clk = 1'b0;
    a_in = '0; b_in = '0; a2b_en = 1'b1; b2a_en_n = 1'b0; b_src_reg = 1'b0; a_src_reg = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 b_oe", {31'd0, b_oe}, 32'd0);
    chk("R1 a_oe", {31'd0, a_oe}, 32'd0);
    chk("R1 b_out", {24'd0, b_out}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4: capture under mixed controls, same cycle
    cycle("R4", 8'hA5, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle("R6", 8'h11, 8'h22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle("R7", 8'h33, 8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle("R2", 8'hC3, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cycle("R3", 8'h77, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    cycle("R5", 8'h3C, 8'hE1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle("R9", 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R10: registers hold across many control/data changes with idle capture clocks
    for (int i = 0; i < 40; i++)
      cycle("R10", W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'b0, 1'b0);
    cycle("R10", 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R11: mid-cycle select and data change stays invisible until the next edge
    cycle("R5", 8'h3C, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    b_src_reg = 1'b1; a_src_reg = 1'b1; a_in = 8'h81; b_in = 8'h18;
    #2;
    chk("R11 b_out", {24'd0, b_out}, 32'h3C);
    chk("R11 a_out", {24'd0, a_out}, 32'h5A);
    @(negedge clk);
    chk("R11 b_out after edge", {24'd0, b_out}, {24'd0, m_a});
    chk("R11 a_out after edge", {24'd0, a_out}, {24'd0, m_b});

    // random traffic
    for (int i = 0; i < 400; i++)
      cycle("R5/R6/R7/R8/R9 rand", W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);

    // R1: reset after non-zero captures clears the registers
    cycle("R4", 8'hDE, 8'hAD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 b_oe mid", {31'd0, b_oe}, 32'd0);
    chk("R1 a_oe mid", {31'd0, a_oe}, 32'd0);
    chk("R1 a_out mid", {24'd0, a_out}, 32'd0);
    m_a = '0; m_b = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cycle("R1", 8'h5F, 8'hF5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule